// File: doc/BRIEF.md
# Four-Stage Accumulator Pipeline with Branch Squash

This block is an in-order pipeline for a small accumulator machine. Each instruction passes through four stages in a fixed order: fetch from the instruction port, decode with effective-address formation, operand read from the data port, and execute with result update. The instruction port and the data port are separate synchronous memories, so an instruction fetch and an operand read proceed in the same cycle. The data port has a separate read address and write address, so an operand read and a store can also share a cycle.

Conditional and unconditional branches resolve only in the execute stage. A taken branch discards the three younger instructions already in flight and restarts fetch at the target on the next cycle. When an instruction in operand read needs a memory word that the store in execute has not yet written, the front of the pipe holds for one cycle and a bubble enters execute. A retire strobe with the retiring address lets a checker compare the completion order against a program-order model.

Top module: `acc_pipe4`

## Requirements
- R1: Instruction word is 16 bits. The opcode is bits [15:12]: 0 no-op, 1 load (acc = M[ea]), 2 add (acc = acc + M[ea]), 3 subtract (acc = acc - M[ea]), 4 store (M[ea] = acc), 5 branch to target when acc is zero, 6 unconditional jump. Any other code acts as a no-op. The effective address is bits [DA_W-1:0] and the branch target is bits [IA_W-1:0]. Memory contents and retire order match sequential execution of the program.
- R2: With no hazard and no taken branch, instructions retire on consecutive cycles, and retire_pc follows program order.
- R3: A store in execute and an operand read of a different address in operand-read proceed in the same cycle without any delay.
- R4: On a taken branch, the three younger instructions never retire, never write data memory and never change the accumulator.
- R5: The branch target is presented on imem_addr in the cycle after the branch retires. The target instruction retires four cycles after the branch.
- R6: In the three cycles that follow a taken branch, retire_valid stays low.
- R7: When the operand-read instruction reads the address that the store in execute writes, the pipe inserts exactly one bubble. The reader retires two cycles after the store and sees the stored value.
- R8: Reset is synchronous and active low. It clears every stage, causes no write and points fetch at address 0. The instruction at address 0 retires three clock edges after reset is released.
- R9: A branch on zero whose accumulator is non-zero squashes nothing. The instruction after it retires in the next cycle.
- R10: A branch that is itself squashed does not redirect fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | IA_W | Instruction fetch address; the word returns one cycle later |
| imem_rdata | input | 16 | Instruction word for the previous cycle's address |
| dmem_re | output | 1 | Operand read enable |
| dmem_raddr | output | DA_W | Operand read address |
| dmem_rdata | input | DW | Operand read data, one cycle after the read |
| dmem_we | output | 1 | Store write enable |
| dmem_waddr | output | DA_W | Store address |
| dmem_wdata | output | DW | Store data (the accumulator) |
| retire_valid | output | 1 | An instruction completes this cycle |
| retire_pc | output | IA_W | Address of the completing instruction |

## Verification
The assertions check the local cycle rules on every cycle. A taken branch empties the younger stages, and fetch moves to the target in the following cycle. A stall lasts exactly one cycle and leaves the operand-read stage unchanged. An instruction that leaves operand read with no stall and no squash retires in the next cycle. A squashed slot does not touch the accumulator. Only the bench scenarios can show the end-to-end behaviour. They cover the exact retire schedule, including the four-cycle refill gap and the one-cycle store-to-load bubble. They also show that squashed stores and a squashed jump leave no trace in memory or in the fetch path, and that the final memory image matches sequential execution.

// File: rtl/acc_pipe_pkg.sv
// Shared opcode encoding and decode helpers for the accumulator pipeline.
// Assumes a 16-bit instruction with a 4-bit opcode in the top nibble.
package acc_pipe_pkg;

    localparam int INSTR_W = 16;
    localparam int OP_LSB  = 12;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_STORE = 4'd4,
        OP_BRZ   = 4'd5,
        OP_JMP   = 4'd6
    } op_e;

    // Map a raw opcode nibble to an operation; unknown codes become no-ops.
    function automatic op_e op_decode(input logic [3:0] raw);
        case (raw)
            4'd1:    return OP_LOAD;
            4'd2:    return OP_ADD;
            4'd3:    return OP_SUB;
            4'd4:    return OP_STORE;
            4'd5:    return OP_BRZ;
            4'd6:    return OP_JMP;
            default: return OP_NOP;
        endcase
    endfunction

    // True for operations that read a data memory operand.
    function automatic logic reads_mem(input op_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/acc_pipe_fetch.sv
// Program counter and fetch address generation.
// Assumes a synchronous instruction memory: the address given in one cycle
// yields its word in the next. During a stall the word held in decode is
// fetched again, so no separate instruction hold register is needed.
module acc_pipe_fetch #(
    parameter int IA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            redirect,
    input  logic [IA_W-1:0] target,
    input  logic [IA_W-1:0] de_pc,
    output logic [IA_W-1:0] pc,
    output logic [IA_W-1:0] imem_addr
);

    // Advance, hold or redirect the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (redirect)
            pc <= target;
        else if (!stall)
            pc <= pc + IA_W'(1);
    end

    // Re-fetch the decode-stage word while stalled, otherwise fetch at pc.
    always_comb begin
        imem_addr = stall ? de_pc : pc;
    end

endmodule

// File: rtl/acc_pipe_decode.sv
// Decode stage: splits the instruction into an operation and an address
// field; the effective address is the direct field. Purely combinational.
module acc_pipe_decode
    import acc_pipe_pkg::*;
#(
    parameter int FLD_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    output op_e                op,
    output logic [FLD_W-1:0]   fld
);

    // Form the operation and the effective-address field.
    always_comb begin
        op  = op_decode(instr[INSTR_W-1:OP_LSB]);
        fld = instr[FLD_W-1:0];
    end

    // Bits between the field and the opcode carry no meaning.
    generate
        if (FLD_W < OP_LSB) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^instr[OP_LSB-1:FLD_W];
        end
    endgenerate

endmodule

// File: rtl/acc_pipe_hazard.sv
// Store-to-load hazard detector. Assumes the data memory returns the old
// word when read and written at the same address in the same cycle, so a
// reader directly behind a matching store must wait one cycle.
module acc_pipe_hazard
    import acc_pipe_pkg::*;
#(
    parameter int DA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            of_v,
    input  op_e             of_op,
    input  logic [DA_W-1:0] of_ea,
    input  logic            ex_v,
    input  op_e             ex_op,
    input  logic [DA_W-1:0] ex_ea,
    output logic            stall
);

    // Detect an operand read of the address the executing store writes.
    always_comb begin
        stall = of_v && reads_mem(of_op) && ex_v && (ex_op == OP_STORE)
                && (ex_ea == of_ea);
    end

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);  // R7

endmodule

// File: rtl/acc_pipe_exec.sv
// Execute stage: updates the accumulator, drives the store port and
// resolves branches. Assumes operand data for the executing instruction
// arrives on rdata in this cycle (read issued one cycle earlier).
module acc_pipe_exec
    import acc_pipe_pkg::*;
#(
    parameter int IA_W = 8,
    parameter int DA_W = 8,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_v,
    input  op_e             ex_op,
    input  logic [DA_W-1:0] ex_ea,
    input  logic [IA_W-1:0] ex_tgt,
    input  logic [DW-1:0]   rdata,
    output logic            taken,
    output logic [IA_W-1:0] target,
    output logic            we,
    output logic [DA_W-1:0] waddr,
    output logic [DW-1:0]   wdata
);

    logic [DW-1:0] acc;

    // Accumulator update for valid arithmetic and load operations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (ex_v) begin
            case (ex_op)
                OP_LOAD: acc <= rdata;
                OP_ADD:  acc <= acc + rdata;
                OP_SUB:  acc <= acc - rdata;
                default: acc <= acc;
            endcase
        end
    end

    // Branch resolution and store port drive.
    always_comb begin
        taken  = ex_v && ((ex_op == OP_JMP) || ((ex_op == OP_BRZ) && (acc == '0)));
        target = ex_tgt;
        we     = ex_v && (ex_op == OP_STORE);
        waddr  = ex_ea;
        wdata  = acc;
    end

    AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_v |=> acc == $past(acc));  // R4

endmodule

// File: rtl/acc_pipe4.sv
// Four-stage in-order accumulator pipeline: fetch, decode with effective
// address, operand read, execute. Each stage register carries a valid bit;
// a taken branch in execute clears all younger valid bits, and a store-to-
// load hazard holds fetch, decode and operand read for one cycle.
// Assumes synchronous instruction and data memories with one-cycle latency.
module acc_pipe4
    import acc_pipe_pkg::*;
#(
    parameter int IA_W = 8,
    parameter int DA_W = 8,
    parameter int DW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IA_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               dmem_re,
    output logic [DA_W-1:0]    dmem_raddr,
    input  logic [DW-1:0]      dmem_rdata,
    output logic               dmem_we,
    output logic [DA_W-1:0]    dmem_waddr,
    output logic [DW-1:0]      dmem_wdata,
    output logic               retire_valid,
    output logic [IA_W-1:0]    retire_pc
);

    localparam int FLD_W = (IA_W > DA_W) ? IA_W : DA_W;

    logic             de_v, of_v, ex_v;
    logic [IA_W-1:0]  de_pc, of_pc, ex_pc;
    op_e              of_op, ex_op, dec_op;
    logic [FLD_W-1:0] of_fld, ex_fld, dec_fld;
    logic [IA_W-1:0]  pc, br_target;
    logic             stall, taken;

    acc_pipe_fetch #(.IA_W(IA_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .stall(stall), .redirect(taken),
        .target(br_target), .de_pc(de_pc), .pc(pc), .imem_addr(imem_addr)
    );

    acc_pipe_decode #(.FLD_W(FLD_W)) u_decode (
        .instr(imem_rdata), .op(dec_op), .fld(dec_fld)
    );

    acc_pipe_hazard #(.DA_W(DA_W)) u_hazard (
        .clk(clk), .rst_n(rst_n),
        .of_v(of_v), .of_op(of_op), .of_ea(of_fld[DA_W-1:0]),
        .ex_v(ex_v), .ex_op(ex_op), .ex_ea(ex_fld[DA_W-1:0]),
        .stall(stall)
    );

    acc_pipe_exec #(.IA_W(IA_W), .DA_W(DA_W), .DW(DW)) u_exec (
        .clk(clk), .rst_n(rst_n), .ex_v(ex_v), .ex_op(ex_op),
        .ex_ea(ex_fld[DA_W-1:0]), .ex_tgt(ex_fld[IA_W-1:0]),
        .rdata(dmem_rdata), .taken(taken), .target(br_target),
        .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata)
    );

    // Stage registers: squash on taken branch, hold front on stall, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_v   <= 1'b0;
            of_v   <= 1'b0;
            ex_v   <= 1'b0;
            de_pc  <= '0;
            of_pc  <= '0;
            ex_pc  <= '0;
            of_op  <= OP_NOP;
            ex_op  <= OP_NOP;
            of_fld <= '0;
            ex_fld <= '0;
        end else if (taken) begin
            de_v <= 1'b0;
            of_v <= 1'b0;
            ex_v <= 1'b0;
        end else if (stall) begin
            ex_v <= 1'b0;
        end else begin
            de_v   <= 1'b1;
            de_pc  <= pc;
            of_v   <= de_v;
            of_pc  <= de_pc;
            of_op  <= dec_op;
            of_fld <= dec_fld;
            ex_v   <= of_v;
            ex_pc  <= of_pc;
            ex_op  <= of_op;
            ex_fld <= of_fld;
        end
    end

    // Operand read port and retire trace.
    always_comb begin
        dmem_re      = of_v && reads_mem(of_op);
        dmem_raddr   = of_fld[DA_W-1:0];
        retire_valid = ex_v;
        retire_pc    = ex_pc;
    end

    AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !de_v && !of_v && !ex_v);  // R4

    AST_REDIRECT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> imem_addr == $past(br_target));  // R5

    AST_REFILL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(taken) |-> !retire_valid && !of_v);  // R6

    AST_IN_ORDER_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (of_v && !stall && !taken) |=> retire_valid && retire_pc == $past(of_pc));  // R2

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !ex_v && of_v && of_pc == $past(of_pc));  // R7

endmodule

// File: tb/acc_pipe4_test.sv
`timescale 1ns/1ps
module acc_pipe4_test;

    localparam int IA_W = 8;
    localparam int DA_W = 8;
    localparam int DW   = 16;
    localparam int NCYC = 90;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IA_W-1:0] imem_addr;
    logic [15:0]     imem_rdata;
    logic            dmem_re, dmem_we, retire_valid;
    logic [DA_W-1:0] dmem_raddr, dmem_waddr;
    logic [DW-1:0]   dmem_rdata, dmem_wdata;
    logic [IA_W-1:0] retire_pc;

    logic [15:0] rom [0:255];
    logic [15:0] ram [0:255];
    logic [15:0] mm  [0:255];

    bit    exp_rv [0:NCYC-1];
    int    exp_pc [0:NCYC-1];
    bit    exp_we [0:NCYC-1];
    int    exp_wa [0:NCYC-1];
    int    exp_wd [0:NCYC-1];
    string exp_tag[0:NCYC-1];

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    bit saw40 = 0;

    always #2 clk = ~clk;

    acc_pipe4 #(.IA_W(IA_W), .DA_W(DA_W), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_re(dmem_re), .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .retire_valid(retire_valid), .retire_pc(retire_pc)
    );

    // Synchronous memories: one-cycle read latency, read returns the old word.
    always @(posedge clk) imem_rdata <= rom[imem_addr];
    always @(posedge clk) begin
        if (dmem_re) dmem_rdata <= ram[dmem_raddr];
        if (dmem_we) ram[dmem_waddr] <= dmem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input int op, input int f);
        return {op[3:0], 4'h0, f[7:0]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            rom[i] = 16'h0; ram[i] = 16'h0; mm[i] = 16'h0;
        end
    endtask

    // Sequential reference: retire cycle, pc and store of every instruction.
    task automatic build_model();
        int pc = 0, t = 3, acc = 0, op, f, npc, nop, nf;
        bit taken;
        string tag = "R8";
        for (int i = 0; i < NCYC; i++) begin
            exp_rv[i] = 0; exp_we[i] = 0; exp_pc[i] = 0;
            exp_wa[i] = 0; exp_wd[i] = 0; exp_tag[i] = "R6";
        end
        while (t < NCYC) begin
            op = rom[pc][15:12]; f = rom[pc][7:0]; taken = 0;
            exp_rv[t] = 1; exp_pc[t] = pc; exp_tag[t] = tag;
            case (op)
                1: acc = mm[f];
                2: acc = (acc + mm[f]) & 16'hFFFF;
                3: acc = (acc - mm[f]) & 16'hFFFF;
                4: begin mm[f] = acc[15:0]; exp_we[t] = 1; exp_wa[t] = f; exp_wd[t] = acc; end
                5: taken = (acc == 0);
                6: taken = 1;
                default: ;
            endcase
            npc = taken ? f : (pc + 1) % 256;
            nop = rom[npc][15:12]; nf = rom[npc][7:0];
            if (taken) begin t += 4; tag = "R5"; end
            else if (op == 4 && nop >= 1 && nop <= 3 && nf == f) begin t += 2; tag = "R7"; end
            else if (op == 4) begin t += 1; tag = "R3"; end
            else if (op == 5) begin t += 1; tag = "R9"; end
            else begin t += 1; tag = "R2"; end
            pc = npc;
        end
    endtask

    // Compare ports against the model on every cycle after release.
    task automatic run_compare();
        for (int k = 0; k < NCYC; k++) begin
            if (k > 0) begin @(posedge clk); @(negedge clk); end
            if (k == 0) begin
                chk(retire_valid == 0, "R8", "retire_valid at release", retire_valid, 0);
                chk(imem_addr == 0, "R8", "imem_addr at release", imem_addr, 0);
                chk(dmem_we == 0, "R8", "dmem_we at release", dmem_we, 0);
            end
            if (retire_valid && retire_pc == 40) saw40 = 1;
            chk(retire_valid == exp_rv[k], exp_tag[k], $sformatf("retire_valid cycle %0d", k),
                retire_valid, exp_rv[k]);
            if (exp_rv[k] && retire_valid)
                chk(retire_pc == exp_pc[k], exp_tag[k], $sformatf("retire_pc cycle %0d", k),
                    retire_pc, exp_pc[k]);
            chk(dmem_we == exp_we[k], exp_we[k] ? "R1" : "R4",
                $sformatf("dmem_we cycle %0d", k), dmem_we, exp_we[k]);
            if (exp_we[k] && dmem_we) begin
                chk(dmem_waddr == exp_wa[k], "R1", "dmem_waddr", dmem_waddr, exp_wa[k]);
                chk(dmem_wdata == exp_wd[k], "R1", "dmem_wdata", dmem_wdata, exp_wd[k]);
            end
        end
    endtask

    initial begin
        // Program A: hazards, not-taken and taken branch, squashed jump and stores.
        clear_mem();
        ram[10] = 5; ram[11] = 3; mm[10] = 5; mm[11] = 3;
        rom[0]  = ins(1, 10); rom[1]  = ins(2, 11); rom[2]  = ins(4, 20);
        rom[3]  = ins(1, 20); rom[4]  = ins(3, 10); rom[5]  = ins(5, 30);
        rom[6]  = ins(4, 21); rom[7]  = ins(3, 11); rom[8]  = ins(5, 12);
        rom[9]  = ins(6, 40); rom[10] = ins(4, 23); rom[11] = ins(4, 24);
        rom[12] = ins(2, 10); rom[13] = ins(4, 25); rom[14] = ins(2, 25);
        rom[15] = ins(4, 26); rom[16] = ins(6, 16);
        build_model();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        run_compare();
        chk(!saw40, "R10", "squashed jump reached pc 40", saw40, 0);
        chk(ram[20] == 8,  "R1", "mem[20]", ram[20], 8);
        chk(ram[26] == 10, "R1", "mem[26]", ram[26], 10);
        chk(ram[23] == 0,  "R4", "squashed store mem[23]", ram[23], 0);
        chk(ram[24] == 0,  "R4", "squashed store mem[24]", ram[24], 0);

        // Mid-run reset.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(retire_valid == 0, "R8", "retire_valid in reset", retire_valid, 0);
        chk(imem_addr == 0, "R8", "imem_addr in reset", imem_addr, 0);
        chk(dmem_we == 0, "R8", "dmem_we in reset", dmem_we, 0);

        // Program B: countdown loop with a backward jump.
        clear_mem();
        ram[0] = 3; ram[1] = 1; mm[0] = 3; mm[1] = 1; ram[2] = 7; mm[2] = 7;
        rom[0] = ins(1, 0); rom[1] = ins(3, 1); rom[2] = ins(4, 0);
        rom[3] = ins(5, 6); rom[4] = ins(6, 1); rom[5] = ins(0, 0);
        rom[6] = ins(4, 2); rom[7] = ins(6, 7);
        build_model();
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        run_compare();
        chk(ram[0] == mm[0], "R1", "countdown mem[0]", ram[0], mm[0]);
        chk(ram[2] == mm[2], "R1", "final store mem[2]", ram[2], mm[2]);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule